// File: doc/BRIEF.md
# USB Host Attach and Reset Sequencer

This block sits beside a USB host port and steps through the timed part of bringing a newly connected device onto the bus. Software enables host operation. From then on the block watches the sampled levels of the two data lines and notices when a device pulls one of them up out of the single-ended-zero idle. It then lets the device's supply settle and reads the idle line level to decide between low and full speed. Next it asks the transceiver to drive bus reset for a fixed time, turns on start-of-frame generation the moment reset ends, and reports ready after a recovery pause.

Every duration is counted in pulses of a one-millisecond tick input, so a faster tick compresses the whole sequence without changing any parameter. If the lines fall back to single-ended zero for longer than a debounce window while the device settles or recovers, the sequence is abandoned and the block waits for a new attach. Enumeration, the analog front end and the line pull resistors belong to other blocks.

Top module: `ush_attach_seq`

## Requirements
- R1: With `host_en` high, `attach_irq` is set when the registered line state goes from SE0 (`line_st` = 2'b00, bit 1 is D+, bit 0 is D-) to any non-SE0 value. A line that is already non-SE0 when the block starts waiting sets nothing.
- R2: `sof_en` stays low while the block is off, waiting for an attach, settling or driving bus reset.
- R3: `bus_reset` rises on the (STAB_MS+1)-th tick counted after the attach is taken, so at least STAB_MS whole milliseconds pass.
- R4: When settling ends, `low_speed` is loaded from the D+ level: 0 if D+ (bit 1) is high, 1 otherwise. It then holds while reset is driven.
- R5: `bus_reset` stays high for RST_MS+1 ticks and then falls.
- R6: `sof_en` rises in the same cycle that `bus_reset` falls at the end of reset, and it stays high in recovery and ready.
- R7: `ready` rises on the (RECOV_MS+1)-th tick after reset is released.
- R8: `attach_irq` stays set until a cycle with `attach_clr` high clears it.
- R9: During settling or recovery, SE0 seen on DEB_MS+1 consecutive ticks returns the block to waiting for an attach and drops every sequence output. A shorter SE0 run has no effect, and the settle timer keeps counting through it.
- R10: When `host_en` is low, `low_speed`, `bus_reset`, `sof_en` and `ready` are low from the next cycle on. All outputs are low out of reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_en | input | 1 | Host operation enable from software |
| line_st | input | 2 | Synchronized line levels, bit 1 D+, bit 0 D- |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| attach_clr | input | 1 | Write-one-to-clear for the attach flag |
| attach_irq | output | 1 | Sticky attach interrupt flag |
| low_speed | output | 1 | Detected device speed, 1 for low speed |
| bus_reset | output | 1 | Request to drive SE0 reset on the bus |
| sof_en | output | 1 | Start-of-frame generation enable |
| ready | output | 1 | Device recovered and ready for enumeration |

## Verification
A wrong internal phase or a miscounted timer shows up at the ports as an edge of `bus_reset`, `sof_en` or `ready` that comes at the wrong tick. A behavioural model of the phases, compared on every clock, catches this within one cycle of the divergence. The measured tick counts from attach to reset, across reset and through recovery are also checked against the parameter values directly. Two faults stay hidden until settling ends: a debounce counter that does not clear, and a speed sample taken from the wrong line. They appear as an early return to waiting or as a wrong `low_speed` value on the first cycle of reset.

// File: rtl/ush_pkg.sv
package ush_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_WAIT,
    ST_SETTLE,
    ST_BUSRST,
    ST_RECOVER,
    ST_READY
  } seq_state_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/ush_line_sampler.sv
module ush_line_sampler #(
  parameter int LW     = 2,
  parameter int DP_BIT = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] line_in,
  output logic          se0_now,
  output logic          dp_level,
  output logic          attach_edge
);
  logic [LW-1:0] line_q;
  logic          prev_se0;

  // Reset to an all-ones line so that no attach edge is seen right after reset
  always_ff @(posedge clk) begin
    if (rst) begin
      line_q   <= '1;
      prev_se0 <= 1'b0;
    end else begin
      line_q   <= line_in;
      prev_se0 <= se0_now;
    end
  end

  assign se0_now     = (line_q == '0);
  assign dp_level    = line_q[DP_BIT];
  assign attach_edge = prev_se0 && !se0_now;
endmodule

// File: rtl/ush_tick_timer.sv
module ush_tick_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          expire
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)        cnt <= '0;
    else if (clear) cnt <= '0;
    else if (tick)  cnt <= cnt + CW'(1);
  end

  // Fires on the tick that arrives once `limit` ticks have already been counted
  assign expire = tick && (cnt == limit);
endmodule

// File: rtl/ush_se0_filter.sv
module ush_se0_filter #(
  parameter int LIMIT = 3,
  parameter int CW    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic arm,
  input  logic se0,
  input  logic tick,
  output logic trip
);
  logic [CW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= '0;
    end else if (clear || !arm || !se0) begin
      run <= '0;
    end else if (tick && (run != CW'(LIMIT))) begin
      run <= run + CW'(1);
    end
  end

  assign trip = arm && se0 && tick && (run == CW'(LIMIT));
endmodule

// File: rtl/ush_attach_seq.sv
module ush_attach_seq
  import ush_pkg::*;
#(
  parameter int STAB_MS  = 100,
  parameter int RST_MS   = 50,
  parameter int RECOV_MS = 10,
  parameter int DEB_MS   = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       host_en,
  input  logic [1:0] line_st,
  input  logic       ms_tick,
  input  logic       attach_clr,
  output logic       attach_irq,
  output logic       low_speed,
  output logic       bus_reset,
  output logic       sof_en,
  output logic       ready
);
  localparam int MAX_MS = max3(STAB_MS, RST_MS, RECOV_MS);
  localparam int TW     = $clog2(MAX_MS + 1) + 1;
  localparam int DW     = $clog2(DEB_MS + 1) + 1;

  seq_state_t    state, nxt;
  logic          se0_now, dp_level, attach_edge;
  logic          expire, trip, phase_change, arm;
  logic [TW-1:0] limit;

  ush_line_sampler #(.LW(2), .DP_BIT(1)) u_line (
    .clk         (clk),
    .rst         (rst),
    .line_in     (line_st),
    .se0_now     (se0_now),
    .dp_level    (dp_level),
    .attach_edge (attach_edge)
  );

  ush_tick_timer #(.CW(TW)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .clear  (phase_change),
    .tick   (ms_tick),
    .limit  (limit),
    .expire (expire)
  );

  ush_se0_filter #(.LIMIT(DEB_MS), .CW(DW)) u_deb (
    .clk   (clk),
    .rst   (rst),
    .clear (phase_change),
    .arm   (arm),
    .se0   (se0_now),
    .tick  (ms_tick),
    .trip  (trip)
  );

  assign arm = (state == ST_SETTLE) || (state == ST_RECOVER);

  always_comb begin
    unique case (state)
      ST_SETTLE:  limit = TW'(STAB_MS);
      ST_BUSRST:  limit = TW'(RST_MS);
      ST_RECOVER: limit = TW'(RECOV_MS);
      default:    limit = '0;
    endcase
  end

  always_comb begin
    nxt = state;
    if (!host_en) begin
      nxt = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF:     nxt = ST_WAIT;
        ST_WAIT:    if (attach_edge) nxt = ST_SETTLE;
        ST_SETTLE:  if (trip) nxt = ST_WAIT; else if (expire) nxt = ST_BUSRST;
        ST_BUSRST:  if (expire) nxt = ST_RECOVER;
        ST_RECOVER: if (trip) nxt = ST_WAIT; else if (expire) nxt = ST_READY;
        ST_READY:   nxt = ST_READY;
        default:    nxt = ST_OFF;
      endcase
    end
  end

  assign phase_change = (nxt != state);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_OFF;
      attach_irq <= 1'b0;
      low_speed  <= 1'b0;
      bus_reset  <= 1'b0;
      sof_en     <= 1'b0;
      ready      <= 1'b0;
    end else begin
      state     <= nxt;
      bus_reset <= (nxt == ST_BUSRST);
      sof_en    <= (nxt == ST_RECOVER) || (nxt == ST_READY);
      ready     <= (nxt == ST_READY);

      if ((state == ST_WAIT) && (nxt == ST_SETTLE)) attach_irq <= 1'b1;
      else if (attach_clr)                          attach_irq <= 1'b0;

      if ((state == ST_SETTLE) && (nxt == ST_BUSRST))  low_speed <= !dp_level;
      else if ((nxt == ST_OFF) || (nxt == ST_WAIT))    low_speed <= 1'b0;
    end
  end
endmodule

// File: rtl/ush_attach_chk.sv
module ush_attach_chk (
  input logic clk,
  input logic rst,
  input logic host_en,
  input logic attach_clr,
  input logic attach_irq,
  input logic low_speed,
  input logic bus_reset,
  input logic sof_en,
  input logic ready
);
  // R2: no start-of-frame while reset is driven
  assert_no_sof_in_reset_R2: assert property (@(posedge clk) disable iff (rst)
    !(sof_en && bus_reset));

  // R6: end of reset under an enabled host turns frames on in the same cycle
  assert_sof_at_reset_end_R6: assert property (@(posedge clk) disable iff (rst)
    ($fell(bus_reset) && $past(host_en)) |-> sof_en);

  // R7: ready only with frames running and the bus out of reset
  assert_ready_with_sof_R7: assert property (@(posedge clk) disable iff (rst)
    ready |-> (sof_en && !bus_reset));

  // R8: attach flag survives any cycle without a clear
  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (attach_irq && !attach_clr) |=> attach_irq);

  // R4: speed result holds while reset is driven
  assert_speed_held_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_reset && $past(bus_reset)) |-> $stable(low_speed));

  // R10: host disable drops the sequence outputs one cycle later
  assert_off_clears_R10: assert property (@(posedge clk) disable iff (rst)
    !host_en |=> (!bus_reset && !sof_en && !ready && !low_speed));
endmodule

bind ush_attach_seq ush_attach_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .host_en    (host_en),
  .attach_clr (attach_clr),
  .attach_irq (attach_irq),
  .low_speed  (low_speed),
  .bus_reset  (bus_reset),
  .sof_en     (sof_en),
  .ready      (ready)
);

// File: tb/tb_ush_attach_seq.sv
`timescale 1ns/1ps
module tb_ush_attach_seq;
  localparam int STAB  = 100;
  localparam int RSTMS = 50;
  localparam int RECOV = 10;
  localparam int DEB   = 3;

  logic clk = 1'b0;
  logic rst, host_en, ms_tick, attach_clr;
  logic [1:0] line_st;
  logic attach_irq, low_speed, bus_reset, sof_en, ready;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  ush_attach_seq #(.STAB_MS(STAB), .RST_MS(RSTMS), .RECOV_MS(RECOV), .DEB_MS(DEB)) dut (
    .clk(clk), .rst(rst), .host_en(host_en), .line_st(line_st), .ms_tick(ms_tick),
    .attach_clr(attach_clr), .attach_irq(attach_irq), .low_speed(low_speed),
    .bus_reset(bus_reset), .sof_en(sof_en), .ready(ready)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp, input string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase number plus elapsed-millisecond counters
  int  m_ph, m_ms, m_se0;
  logic [1:0] m_line;
  bit  m_prev_zero;
  bit  e_irq, e_ls, e_rst, e_sof, e_rdy;

  always @(posedge clk) begin
    int  lim, nph;
    bit  attach_seen, timed, glitch, done, zero_now;
    if (rst) begin
      m_ph = 0; m_ms = 0; m_se0 = 0; m_line = 2'b11; m_prev_zero = 1'b0;
      e_irq = 0; e_ls = 0; e_rst = 0; e_sof = 0; e_rdy = 0;
    end else begin
      zero_now    = (m_line == 2'b00);
      attach_seen = m_prev_zero && !zero_now;
      timed       = (m_ph >= 2) && (m_ph <= 4);
      lim         = (m_ph == 2) ? STAB : (m_ph == 3) ? RSTMS : (m_ph == 4) ? RECOV : 0;
      glitch      = ((m_ph == 2) || (m_ph == 4)) && zero_now && ms_tick && (m_se0 == DEB);
      done        = timed && ms_tick && (m_ms == lim);
      nph = m_ph;
      if (!host_en)                   nph = 0;
      else if (m_ph == 0)             nph = 1;
      else if (m_ph == 1)             nph = attach_seen ? 2 : 1;
      else if (glitch)                nph = 1;
      else if (done)                  nph = m_ph + 1;
      if (m_ph == 1 && nph == 2)      e_irq = 1;
      else if (attach_clr)            e_irq = 0;
      if (m_ph == 2 && nph == 3)      e_ls = !m_line[1];
      else if (nph <= 1)              e_ls = 0;
      e_rst = (nph == 3);
      e_sof = (nph >= 4);
      e_rdy = (nph == 5);
      if (nph != m_ph) begin
        m_ms = 0; m_se0 = 0;
      end else begin
        if (ms_tick) m_ms++;
        if (!zero_now || !((m_ph == 2) || (m_ph == 4))) m_se0 = 0;
        else if (ms_tick && m_se0 < DEB) m_se0++;
      end
      m_ph = nph;
      m_prev_zero = zero_now;
      m_line = line_st;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(attach_irq == e_irq, "R1", attach_irq, e_irq, "model attach_irq");
      chk(low_speed  == e_ls,  "R4", low_speed,  e_ls,  "model low_speed");
      chk(bus_reset  == e_rst, "R5", bus_reset,  e_rst, "model bus_reset");
      chk(sof_en     == e_sof, "R6", sof_en,     e_sof, "model sof_en");
      chk(ready      == e_rdy, "R7", ready,      e_rdy, "model ready");
    end
  end

  task automatic pulse();
    @(negedge clk) ms_tick = 1'b1;
    @(negedge clk) ms_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_line(input logic [1:0] v);
    @(negedge clk) line_st = v;
    repeat (3) @(negedge clk);
  endtask

  function automatic bit reached(input int which);
    case (which)
      0:       return bus_reset;
      1:       return !bus_reset;
      default: return ready;
    endcase
  endfunction

  task automatic count_ticks(input int which, output int n);
    n = 0;
    while (n < 400 && !reached(which)) begin
      pulse();
      n++;
    end
  endtask

  task automatic clear_irq();
    @(negedge clk) attach_clr = 1'b1;
    @(negedge clk) attach_clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    rst = 1'b1; host_en = 1'b0; line_st = 2'b00; ms_tick = 1'b0; attach_clr = 1'b0;
    repeat (5) @(negedge clk);
    chk({attach_irq, low_speed, bus_reset, sof_en, ready} == 5'b0, "R10", 
        {attach_irq, low_speed, bus_reset, sof_en, ready}, 0, "reset state");
    rst = 1'b0;

    // Full-speed attach
    @(negedge clk) host_en = 1'b1;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 5; i++) pulse();
    chk(attach_irq == 1'b0, "R1", attach_irq, 0, "no attach on idle SE0");
    chk(sof_en == 1'b0, "R2", sof_en, 0, "frames off while waiting");
    set_line(2'b10);
    chk(attach_irq == 1'b1, "R1", attach_irq, 1, "attach on SE0 to J");
    count_ticks(0, n);
    chk(n == STAB + 1, "R3", n, STAB + 1, "ticks to reset");
    chk(low_speed == 1'b0, "R4", low_speed, 0, "full speed");
    chk(sof_en == 1'b0, "R2", sof_en, 0, "frames off in reset");
    set_line(2'b00);
    count_ticks(1, n);
    chk(n == RSTMS + 1, "R5", n, RSTMS + 1, "reset length");
    chk(sof_en == 1'b1, "R6", sof_en, 1, "frames on at reset end");
    set_line(2'b10);
    count_ticks(2, n);
    chk(n == RECOV + 1, "R7", n, RECOV + 1, "recovery length");
    chk(sof_en == 1'b1, "R6", sof_en, 1, "frames on when ready");
    chk(attach_irq == 1'b1, "R8", attach_irq, 1, "flag still set");
    clear_irq();
    chk(attach_irq == 1'b0, "R8", attach_irq, 0, "flag cleared");

    // Host disable
    @(negedge clk) host_en = 1'b0;
    repeat (2) @(negedge clk);
    chk({bus_reset, sof_en, ready, low_speed} == 4'b0, "R10",
        {bus_reset, sof_en, ready, low_speed}, 0, "outputs after disable");

    // Already-connected device: no edge, no attach
    @(negedge clk) host_en = 1'b1;
    for (int i = 0; i < 10; i++) pulse();
    chk(attach_irq == 1'b0, "R1", attach_irq, 0, "no attach without SE0 first");
    chk(bus_reset == 1'b0, "R1", bus_reset, 0, "no sequence without attach");

    // Low-speed attach
    set_line(2'b00);
    set_line(2'b01);
    chk(attach_irq == 1'b1, "R1", attach_irq, 1, "low-speed attach");
    count_ticks(0, n);
    chk(n == STAB + 1, "R3", n, STAB + 1, "ticks to reset, low speed");
    chk(low_speed == 1'b1, "R4", low_speed, 1, "low speed detected");
    clear_irq();
    @(negedge clk) host_en = 1'b0;
    set_line(2'b00);

    // Short SE0 glitch during settling
    @(negedge clk) host_en = 1'b1;
    repeat (3) @(negedge clk);
    set_line(2'b10);
    for (int i = 0; i < 5; i++) pulse();
    set_line(2'b00);
    for (int i = 0; i < DEB; i++) pulse();
    set_line(2'b10);
    count_ticks(0, n);
    chk(n == STAB + 1 - 5 - DEB, "R9", n, STAB + 1 - 5 - DEB, "short glitch ignored");
    clear_irq();
    @(negedge clk) host_en = 1'b0;
    set_line(2'b00);

    // Long SE0 during settling: detach
    @(negedge clk) host_en = 1'b1;
    repeat (3) @(negedge clk);
    set_line(2'b10);
    clear_irq();
    for (int i = 0; i < 5; i++) pulse();
    set_line(2'b00);
    for (int i = 0; i < STAB + 5; i++) pulse();
    chk(bus_reset == 1'b0, "R9", bus_reset, 0, "detach abandons settling");
    chk(attach_irq == 1'b0, "R9", attach_irq, 0, "no new attach yet");
    set_line(2'b10);
    chk(attach_irq == 1'b1, "R9", attach_irq, 1, "re-attach after detach");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule